// File: doc/BRIEF.md
# Hybrid Booth-Logarithmic Approximate Multiplier

This block multiplies two 16-bit two's-complement operands and returns a 32-bit signed product that is exact in every term except one. Each operand is split at bit 14. Bits 15..13 are recoded into a radix-4 Booth digit D = -2·b15 + b14 + b13 in {-2..2}. Bits 13..0 are read as a signed 14-bit low field L, so the operand equals D·2^14 + L. The digit-by-digit term, both digit-by-low cross terms and the alignment are exact. Only the low-by-low term is replaced by a logarithmic estimate built from the leading-one positions of the two low-field magnitudes.

The partial-product rows are sign-extended to 32 bits. Negative selections are formed by inversion, with carry bits injected into free positions of other rows. The rows are then compressed by a carry-save tree and resolved by a parallel-prefix carry-lookahead adder. An output register, enabled by default, gives one cycle of latency. The block suits error-tolerant datapaths such as filters, image kernels and neural-network accumulations, where a few percent of relative error is acceptable in exchange for a smaller partial-product array.

Top module: `booth_log_mult`

## Requirements
- R1: While rst_n is low the product output is 0, and it is still 0 at the first rising edge after rst_n is released.
- R2: With the output register enabled, prod changes only at a rising clock edge and then shows the result for the operands present at that edge.
- R3: When either operand is 0 the product is exactly 0.
- R4: The high digit of an operand is -2·bit15 + bit14 + bit13 and its low field is bits 13..0 read as a signed 14-bit value. When the magnitude of either low field is 0 or a power of two (including -8192), the product equals the exact signed product.
- R5: For nonzero low fields X0 and Y0, the product is X·Y − s·(|X0| − 2^kx)·(|Y0| − 2^ky) in 32-bit two's complement. Here kx = floor(log2|X0|), ky = floor(log2|Y0|), and s is +1 when X0·Y0 > 0 and −1 otherwise.
- R6: The error, exact minus result, has the sign of X0·Y0 (or is zero), and four times its magnitude never exceeds |X0·Y0|.
- R7: Swapping the two operands never changes the product.
- R8: Over uniformly random operands, the mean relative error against the exact product, averaged over nonzero exact products, stays below 6%.
- R9: Full-range operands are handled without overflow: −32768·−32768 gives 0x40000000 and 32767·32767 gives 0x3FFF0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 16 | First two's-complement operand |
| op_b | input | 16 | Second two's-complement operand |
| prod | output | 32 | Approximate signed product |

## Verification
The assertions assume the output register is present and that the operands are stable around each rising edge, so the result seen at one edge belongs to the operands captured at the previous one. They also assume that nothing but reset breaks that pairing. The checker therefore starts comparing only one edge after reset is released. The stimulus drives operands only on falling edges, never touches reset after start-up, and covers the whole 16-bit range: digit boundaries, the most negative low field and random values, all of which remain legal inputs for the bound and exactness properties.

// File: rtl/blm_pkg.sv
`timescale 1ns/1ps
package blm_pkg;

    // Booth digit in sign/magnitude one-hot form: value = (neg ? -1 : 1) * (two ? 2 : one ? 1 : 0)
    typedef struct packed {
        logic neg;
        logic two;
        logic one;
    } bdigit_t;

    // Recode three overlapping bits {b15,b14,b13} into -2*b15 + b14 + b13
    function automatic bdigit_t recode_digit(input logic [2:0] t);
        bdigit_t d;
        d.one = t[1] ^ t[0];
        d.two = (t == 3'b011) | (t == 3'b100);
        d.neg = t[2] & ~(t[1] & t[0]);
        return d;
    endfunction

    // Minimised digit-by-digit product, 4-bit two's complement in {-4..4}
    function automatic logic [3:0] digit_product(input bdigit_t a, input bdigit_t b);
        logic m1, m2, m4, sgn;
        logic [3:0] mag;
        m1  = a.one & b.one;
        m2  = (a.one & b.two) | (a.two & b.one);
        m4  = a.two & b.two;
        sgn = (a.neg ^ b.neg) & (m1 | m2 | m4);
        mag = {1'b0, m4, m2, m1};
        return sgn ? (~mag + 4'd1) : mag;
    endfunction

endpackage

// File: rtl/booth_cross_pp.sv
`timescale 1ns/1ps
module booth_cross_pp
    import blm_pkg::*;
#(
    parameter int LOW = 14,
    parameter int PW  = 32
) (
    input  bdigit_t          dig,
    input  logic [LOW-1:0]   seg,
    output logic [PW-1:0]    row,
    output logic             cin
);
    localparam int UW = PW - LOW;

    logic [UW-1:0] ext;
    logic [UW-1:0] mag;

    always_comb begin
        ext = {{(UW-LOW){seg[LOW-1]}}, seg};
        if (dig.two) begin
            mag = ext << 1;
        end else if (dig.one) begin
            mag = ext;
        end else begin
            mag = '0;
        end
        // only the bits above the alignment point are inverted; the +1 lands at bit LOW
        row = {(dig.neg ? ~mag : mag), {LOW{1'b0}}};
        cin = dig.neg;
    end

endmodule

// File: rtl/log_lowpp.sv
`timescale 1ns/1ps
module log_lowpp #(
    parameter int LOW = 14,
    parameter int PW  = 32
) (
    input  logic [LOW-1:0] x0,
    input  logic [LOW-1:0] y0,
    output logic [PW-1:0]  row_a,
    output logic [PW-1:0]  row_b,
    output logic           neg
);
    localparam int KW = $clog2(LOW);

    logic [LOW-1:0] ax, ay, rx;
    logic [KW-1:0]  kx, ky;
    logic           nz;
    logic [PW-1:0]  pa, pb;

    function automatic logic [KW-1:0] lead_one(input logic [LOW-1:0] v);
        logic [KW-1:0] k;
        k = '0;
        for (int i = 0; i < LOW; i++) begin
            if (v[i]) k = KW'(i);
        end
        return k;
    endfunction

    always_comb begin
        ax  = x0[LOW-1] ? (~x0 + {{(LOW-1){1'b0}}, 1'b1}) : x0;
        ay  = y0[LOW-1] ? (~y0 + {{(LOW-1){1'b0}}, 1'b1}) : y0;
        kx  = lead_one(ax);
        ky  = lead_one(ay);
        nz  = (|ax) & (|ay);
        rx  = ax ^ (LOW'(1) << kx);
        pa  = PW'(ay) << kx;
        pb  = PW'(rx) << ky;
        neg = nz & (x0[LOW-1] ^ y0[LOW-1]);
        if (!nz) begin
            row_a = '0;
            row_b = '0;
        end else begin
            row_a = neg ? ~pa : pa;
            row_b = neg ? ~pb : pb;
        end
    end

endmodule

// File: rtl/csa_3to2.sv
`timescale 1ns/1ps
module csa_3to2 #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] maj;

    always_comb begin
        s   = a ^ b ^ c;
        maj = (a & b) | (a & c) | (b & c);
        cy  = {maj[W-2:0], 1'b0};
    end

endmodule

// File: rtl/prefix_adder.sv
`timescale 1ns/1ps
module prefix_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int N  = W - 1;
    localparam int LV = $clog2(N);

    logic [N-1:0] gv, pv, gn, pn;

    always_comb begin
        gv = a[N-1:0] & b[N-1:0];
        pv = a[N-1:0] ^ b[N-1:0];
        for (int lv = 0; lv < LV; lv++) begin
            gn = gv | (pv & (gv << (1 << lv)));
            pn = pv & ((pv << (1 << lv)) | N'((1 << (1 << lv)) - 1));
            gv = gn;
            pv = pn;
        end
        sum = (a ^ b) ^ {gv, 1'b0};
    end

endmodule

// File: rtl/booth_log_mult.sv
`timescale 1ns/1ps
module booth_log_mult
    import blm_pkg::*;
#(
    parameter int W       = 16,
    parameter int REG_OUT = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] prod
);
    localparam int HI  = 2;
    localparam int LOW = W - HI;
    localparam int PW  = 2 * W;
    localparam int HSH = 2 * LOW;

    typedef struct packed {
        logic [PW-1:0] prod;
    } out_st_t;

    out_st_t st_d;

    bdigit_t        dx, dy;
    logic [3:0]     hh;
    logic [PW-1:0]  row_hh, row_cx, row_cy, row_la, row_lb, row_cr;
    logic           cx_cin, cy_cin, lo_neg;
    logic [PW-1:0]  s1, c1, s2, c2, s3, c3, total;

    always_comb begin
        dx = recode_digit(op_a[W-1:LOW-1]);
        dy = recode_digit(op_b[W-1:LOW-1]);
        hh = digit_product(dx, dy);
    end

    // digit of a times low field of b, and digit of b times low field of a
    booth_cross_pp #(.LOW(LOW), .PW(PW)) cross_x_i (
        .dig (dx),
        .seg (op_b[LOW-1:0]),
        .row (row_cx),
        .cin (cx_cin)
    );

    booth_cross_pp #(.LOW(LOW), .PW(PW)) cross_y_i (
        .dig (dy),
        .seg (op_a[LOW-1:0]),
        .row (row_cy),
        .cin (cy_cin)
    );

    log_lowpp #(.LOW(LOW), .PW(PW)) lowpp_i (
        .x0    (op_a[LOW-1:0]),
        .y0    (op_b[LOW-1:0]),
        .row_a (row_la),
        .row_b (row_lb),
        .neg   (lo_neg)
    );

    // the aligned digit product leaves bits below HSH free for injected carries
    always_comb begin
        row_hh      = PW'($signed(hh)) << HSH;
        row_hh[LOW] = cy_cin;
        row_hh[0]   = lo_neg;
        row_cr      = '0;
        row_cr[LOW] = cx_cin;
        row_cr[0]   = lo_neg;
    end

    csa_3to2 #(.W(PW)) csa0_i (.a(row_hh), .b(row_cx), .c(row_cy), .s(s1), .cy(c1));
    csa_3to2 #(.W(PW)) csa1_i (.a(row_la), .b(row_lb), .c(row_cr), .s(s2), .cy(c2));
    csa_3to2 #(.W(PW)) csa2_i (.a(s1),     .b(c1),     .c(s2),     .s(s3), .cy(c3));

    logic [PW-1:0] s4, c4;
    csa_3to2 #(.W(PW)) csa3_i (.a(s3),     .b(c3),     .c(c2),     .s(s4), .cy(c4));

    prefix_adder #(.W(PW)) final_i (
        .a   (s4),
        .b   (c4),
        .sum (total)
    );

    always_comb begin
        st_d      = '0;
        st_d.prod = total;
    end

    generate
        if (REG_OUT != 0) begin : g_reg
            out_st_t st_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
            assign prod = st_q.prod;
        end else begin : g_comb
            assign prod = st_d.prod;
        end
    endgenerate

endmodule

// File: rtl/booth_log_mult_chk.sv
`timescale 1ns/1ps
module booth_log_mult_chk #(
    parameter int W       = 16,
    parameter int REG_OUT = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic [2*W-1:0] prod
);
    localparam int LOW = W - 2;
    localparam int PW  = 2 * W;
    localparam int XW  = PW + 2;

    logic [W-1:0] a_q, b_q, a_s, b_s;
    logic         vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            vld <= 1'b0;
        end else begin
            a_q <= op_a;
            b_q <= op_b;
            vld <= 1'b1;
        end
    end

    logic signed [XW-1:0] exact, lo, err, x0, y0, ax, ay, abs_e, abs_lo;

    always_comb begin
        a_s    = (REG_OUT != 0) ? a_q : op_a;
        b_s    = (REG_OUT != 0) ? b_q : op_b;
        exact  = XW'($signed(a_s)) * XW'($signed(b_s));
        x0     = XW'($signed(a_s[LOW-1:0]));
        y0     = XW'($signed(b_s[LOW-1:0]));
        lo     = x0 * y0;
        ax     = (x0 < 0) ? -x0 : x0;
        ay     = (y0 < 0) ? -y0 : y0;
        err    = exact - XW'($signed(prod));
        abs_e  = (err < 0) ? -err : err;
        abs_lo = (lo < 0) ? -lo : lo;
    end

    // R1: output is cleared when reset is released
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((REG_OUT != 0) && $rose(rst_n)) |-> (prod == '0));

    // R3: a zero operand yields a zero product
    a_r3_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && (a_s == '0 || b_s == '0)) |-> (prod == '0));

    // R4: a power-of-two (or zero) low-field magnitude makes the result exact
    a_r4_exact_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && ($countones(ax) <= 1 || $countones(ay) <= 1)) |-> (err == '0));

    // R6: error follows the sign of the low-by-low product and never exceeds it
    a_r6_err_direction: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ((lo >= 0) ? (err >= 0 && err <= lo) : (err <= 0 && err >= lo)));

    // R6: error is at most a quarter of the low-by-low magnitude
    a_r6_err_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ((abs_e * 4) <= abs_lo));

endmodule

bind booth_log_mult booth_log_mult_chk #(.W(W), .REG_OUT(REG_OUT)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .prod  (prod)
);

// File: tb/booth_log_mult_tb_top.sv
`timescale 1ns/1ps
module booth_log_mult_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic [31:0] prod;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    booth_log_mult dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (a),
        .op_b  (b),
        .prod  (prod)
    );

    // {op_a, op_b, expected product}
    localparam logic [63:0] VEC [14] = '{
        {16'h0000, 16'h1234, 32'h0000_0000},
        {16'h0003, 16'h0005, 32'h0000_000E},
        {16'h0007, 16'h0007, 32'h0000_0028},
        {16'hFFFD, 16'h0005, 32'hFFFF_FFF2},
        {16'h4000, 16'h0003, 32'h0000_C000},
        {16'h6000, 16'h0003, 32'h0001_2000},
        {16'h8000, 16'h8000, 32'h4000_0000},
        {16'h0064, 16'h0064, 32'h0000_2200},
        {16'h4005, 16'h4003, 32'h1002_000E},
        {16'h03E8, 16'hFFFF, 32'hFFFF_FC18},
        {16'hFFFF, 16'hFFFF, 32'h0000_0001},
        {16'h7FFF, 16'h7FFF, 32'h3FFF_0001},
        {16'h1FFF, 16'h1FFF, 32'h02FF_E000},
        {16'hE000, 16'h0005, 32'hFFFF_6000}
    };

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] va, input logic [15:0] vb);
        @(negedge clk);
        a = va;
        b = vb;
        @(negedge clk);
    endtask

    function automatic int floor_log2(input longint v);
        int k = 0;
        for (int i = 0; i < 20; i++) begin
            if ((v >> i) != 0) k = i;
        end
        return k;
    endfunction

    function automatic longint exact_of(input logic [15:0] va, input logic [15:0] vb);
        return longint'($signed(va)) * longint'($signed(vb));
    endfunction

    function automatic longint low_of(input logic [15:0] v);
        return longint'($signed(v[13:0]));
    endfunction

    // R5 reference: exact product minus the signed residue-by-residue term
    function automatic longint ref_mul(input logic [15:0] va, input logic [15:0] vb);
        longint x0, y0, mx, my, e;
        x0 = low_of(va);
        y0 = low_of(vb);
        mx = (x0 < 0) ? -x0 : x0;
        my = (y0 < 0) ? -y0 : y0;
        if (mx == 0 || my == 0) return exact_of(va, vb);
        e = (mx - (longint'(1) << floor_log2(mx))) * (my - (longint'(1) << floor_log2(my)));
        if ((x0 < 0) != (y0 < 0)) e = -e;
        return exact_of(va, vb) - e;
    endfunction

    function automatic longint p32(input logic [31:0] v);
        return longint'($signed(v));
    endfunction

    logic done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] ra, rb;
        longint      ex, ap, er, lo;
        real         rel_sum;
        int          rel_cnt;

        // R1: output stays cleared during reset
        a = 16'h1234;
        b = 16'h5678;
        repeat (3) @(negedge clk);
        check("R1 in reset", p32(prod), 0);
        rst_n = 1'b1;
        #1;
        check("R1 after release", p32(prod), 0);
        @(negedge clk);
        check("R2 first result", p32(prod), ref_mul(16'h1234, 16'h5678));

        // R2: new operands are not visible before the next rising edge
        a = 16'h0007;
        b = 16'h0007;
        #1;
        check("R2 hold before edge", p32(prod), ref_mul(16'h1234, 16'h5678));
        @(negedge clk);
        check("R2 update after edge", p32(prod), 40);

        // R5 / R9: directed vector table
        for (int i = 0; i < 14; i++) begin
            apply(VEC[i][63:48], VEC[i][47:32]);
            check("R5 table", p32(prod), p32(VEC[i][31:0]));
        end

        // R3: zero operands
        apply(16'h0000, 16'h8000);
        check("R3 zero a", p32(prod), 0);
        apply(16'h7ABC, 16'h0000);
        check("R3 zero b", p32(prod), 0);

        // R4: power-of-two low fields give exact results
        apply(16'h2000, 16'h3A5B);
        check("R4 low -8192", p32(prod), exact_of(16'h2000, 16'h3A5B));
        apply(16'h5A71, 16'h0400);
        check("R4 low 1024", p32(prod), exact_of(16'h5A71, 16'h0400));
        apply(16'hC000, 16'h9123);
        check("R4 low zero", p32(prod), exact_of(16'hC000, 16'h9123));

        // R9: full-range corners
        apply(16'h8000, 16'h8000);
        check("R9 min*min", p32(prod), 64'sh4000_0000);
        apply(16'h7FFF, 16'h8000);
        check("R9 max*min", p32(prod), exact_of(16'h7FFF, 16'h8000));

        // R5 / R6 / R8: random operands
        rel_sum = 0.0;
        rel_cnt = 0;
        for (int i = 0; i < 1500; i++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            apply(ra, rb);
            ap = p32(prod);
            ex = exact_of(ra, rb);
            check("R5 random", ap, ref_mul(ra, rb));
            er = ex - ap;
            lo = low_of(ra) * low_of(rb);
            check("R6 error bound",
                  ((lo >= 0) ? (er >= 0 && er * 4 <= lo) : (er <= 0 && -er * 4 <= -lo)) ? 1 : 0, 1);
            if (ex != 0) begin
                rel_sum += ((er < 0) ? -real'(er) : real'(er)) / ((ex < 0) ? -real'(ex) : real'(ex));
                rel_cnt++;
            end
        end
        check("R8 mean relative error below 6%",
              (rel_sum / real'(rel_cnt) < 0.06) ? 1 : 0, 1);

        // R7: swapped operands give the same product
        for (int i = 0; i < 200; i++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            apply(ra, rb);
            ap = p32(prod);
            apply(rb, ra);
            check("R7 commutative", p32(prod), ap);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule